// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This unit serves a DSP-style integer datapath. It computes a 32-bit result from two operands, an operation code and a 5-bit saturation position. The result is purely combinational. Beside it sits one registered, sticky saturation flag (`q_flag`). Ten operations are provided:
- signed add and subtract that clamp on overflow;
- a signed add that wraps but still reports overflow;
- a doubling that clamps;
- unsigned add and subtract that clamp;
- clamping of a signed value to a chosen bit position, in signed and in unsigned form;
- the same two clamps applied to each 16-bit half of the first operand on its own.

The flag records that saturation happened at some point since it was last cleared. It changes only on a clock edge where `op_valid` is high and the current operation saturated, or where `q_clear` is pulsed. There is no back-pressure. The operands are not a stream: the result follows the inputs in the same cycle whether or not `op_valid` is high. `op_valid` only qualifies whether this cycle's saturation is recorded in the flag. The consumer captures `result` on any edge it likes.

Top module: `sat_arith_unit`

## Requirements
- R1: Op code 0 (saturating signed add): `result` is a+b when no signed overflow occurs. On overflow, defined as both operands having the same sign and the sum's sign differing from a, `result` is 0x7FFFFFFF if a is non-negative and 0x80000000 if a is negative, and saturation is reported.
- R2: Op code 1 (saturating signed subtract): `result` is a-b. On overflow, defined as the operands having different signs and the difference's sign differing from a, `result` clamps as in R1 and saturation is reported.
- R3: Op code 2 (flagging add): `result` is always the wrapped sum a+b. Saturation is reported exactly when the R1 overflow condition holds.
- R4: Op code 3 (doubling): for signed a >= 0x40000000, `result` is 0x7FFFFFFF with saturation. For signed a <= 0xC0000000 (including a = 0xC0000000 itself), `result` is 0x80000000 with saturation. Otherwise `result` is a shifted left by one.
- R5: Op code 4 (unsigned saturating add): `result` is a+b. If the add carries out of bit 31, `result` is 0xFFFFFFFF with saturation.
- R6: Op code 5 (unsigned saturating subtract): `result` is a-b. If b > a (unsigned), `result` is 0 with saturation.
- R7: Op code 6 (signed clamp): a, read as signed, is clamped to the range -(2^s) .. 2^s-1, where s is `sat_pos`. Saturation is reported when the clamp changes the value. With s = 31 the value never changes.
- R8: Op code 7 (unsigned clamp): a, read as signed, is clamped to the range 0 .. 2^s-1. Saturation is reported when the clamp changes the value.
- R9: Op code 8 (dual-half signed clamp): each 16-bit half of a is sign-extended on its own and clamped as in R7 with the same s. The low 16 bits of each clamped value are packed back into the same half. Saturation is reported if either half clamps.
- R10: Op code 9 (dual-half unsigned clamp): the same as R9, with the R8 range.
- R11: `q_flag` becomes 1 on a rising edge where `op_valid` is 1 and the operation saturated, and then stays 1. Saturation with `op_valid` low leaves the flag unchanged. Op codes 10 to 15 give `result` 0 and never report saturation.
- R12: A `q_clear` high at a rising edge clears `q_flag`, unless a recorded saturation arrives on the same edge. In that case the flag stays or becomes 1.
- R13: `rst` high at a rising edge forces `q_flag` to 0. The reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag |
| op_valid | input | 1 | The current operation counts toward the flag |
| op_sel | input | 4 | Operation code 0..9 (10..15 unused) |
| opnd_a | input | 32 | First operand (the value to clamp for codes 6..9) |
| opnd_b | input | 32 | Second operand (add/subtract codes only) |
| sat_pos | input | 5 | Clamp bit position s for codes 6..9 |
| q_clear | input | 1 | Clear strobe for the sticky flag |
| result | output | 32 | Combinational result |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions watch the flag's sequencing on every cycle: reset, stickiness, holding while idle, clearing, and setting after an unsigned carry. They also check range bounds of the result that must always hold: unsigned add never below a, unsigned subtract never above a, unsigned clamp within 2^s-1, and signed add being either the sum or a rail. Exact result values, the doubling threshold at 0xC0000000, per-half packing, set-over-clear priority and the silence of unused codes are shown only by the bench's directed and random scenarios, which are compared against a reference model.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_QADD   = 4'd0,
    OP_QSUB   = 4'd1,
    OP_ADDQ   = 4'd2,
    OP_QDBL   = 4'd3,
    OP_UQADD  = 4'd4,
    OP_UQSUB  = 4'd5,
    OP_SSAT   = 4'd6,
    OP_USAT   = 4'd7,
    OP_SSAT16 = 4'd8,
    OP_USAT16 = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_arith_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic [DW-1:0]  res,
  output logic           sat
);
  localparam int MSB = DW - 1;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] DBL_HI = {2'b01, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] DBL_LO = {2'b11, {(DW-2){1'b0}}};

  logic [DW:0]   sum_x, dif_x;
  logic          ovf_add, ovf_sub, carry, borrow, dbl_hi, dbl_lo;
  logic [DW-1:0] rail;

  assign sum_x   = {1'b0, a} + {1'b0, b};
  assign dif_x   = {1'b0, a} - {1'b0, b};
  assign carry   = sum_x[DW];
  assign borrow  = dif_x[DW];
  assign ovf_add = (a[MSB] == b[MSB]) && (sum_x[MSB] != a[MSB]);
  assign ovf_sub = (a[MSB] != b[MSB]) && (dif_x[MSB] != a[MSB]);
  assign rail    = a[MSB] ? SMIN : SMAX;
  assign dbl_hi  = $signed(a) >= $signed(DBL_HI);
  assign dbl_lo  = $signed(a) <= $signed(DBL_LO);

  always_comb begin
    res = '0;
    sat = 1'b0;
    case (op)
      OP_QADD: begin
        sat = ovf_add;
        res = ovf_add ? rail : sum_x[DW-1:0];
      end
      OP_QSUB: begin
        sat = ovf_sub;
        res = ovf_sub ? rail : dif_x[DW-1:0];
      end
      OP_ADDQ: begin
        sat = ovf_add;
        res = sum_x[DW-1:0];
      end
      OP_QDBL: begin
        sat = dbl_hi | dbl_lo;
        if (dbl_hi)      res = SMAX;
        else if (dbl_lo) res = SMIN;
        else             res = {a[DW-2:0], 1'b0};
      end
      OP_UQADD: begin
        sat = carry;
        res = carry ? {DW{1'b1}} : sum_x[DW-1:0];
      end
      OP_UQSUB: begin
        sat = borrow;
        res = borrow ? '0 : dif_x[DW-1:0];
      end
      default: begin
        res = '0;
        sat = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W  = 32,
  parameter int PW = 5
) (
  input  logic [W-1:0]  val,
  input  logic [PW-1:0] pos,
  input  logic          uns,
  output logic [W-1:0]  out,
  output logic          clamped
);
  localparam int XW = W + 1;

  logic signed [XW-1:0] v_ext, lim_hi, lim_lo;
  logic wide, over, under;

  assign v_ext  = $signed({val[W-1], val});
  assign wide   = (32'(pos) >= W - 1);
  assign lim_hi = $signed((XW'(1) << pos) - XW'(1));
  assign lim_lo = ~lim_hi;
  assign over   = !wide && (v_ext > lim_hi);
  assign under  = uns ? v_ext[XW-1] : (!wide && (v_ext < lim_lo));

  always_comb begin
    if (over)       out = lim_hi[W-1:0];
    else if (under) out = uns ? '0 : lim_lo[W-1:0];
    else            out = val;
    clamped = over | under;
  end
endmodule

// File: rtl/sat_qflag.sv
module sat_qflag (
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= 1'b0;
    else if (set_en) q <= 1'b1;
    else if (clr)    q <= 1'b0;
  end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
  import sat_arith_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_sel,
  input  logic [DW-1:0]  opnd_a,
  input  logic [DW-1:0]  opnd_b,
  input  logic [PW-1:0]  sat_pos,
  input  logic           q_clear,
  output logic [DW-1:0]  result,
  output logic           q_flag
);
  localparam int HW    = DW / 2;
  localparam int LANES = 2;

  logic [DW-1:0] as_res, full_res;
  logic          as_sat, full_sat;
  logic [HW-1:0] half_res [LANES];
  logic [LANES-1:0] half_sat;
  logic          sat_any;

  sat_addsub #(.DW(DW)) u_addsub (
    .op(op_sel), .a(opnd_a), .b(opnd_b), .res(as_res), .sat(as_sat)
  );

  sat_clamp #(.W(DW), .PW(PW)) u_full (
    .val(opnd_a), .pos(sat_pos), .uns(op_sel == OP_USAT),
    .out(full_res), .clamped(full_sat)
  );

  for (genvar h = 0; h < LANES; h++) begin : g_half
    sat_clamp #(.W(HW), .PW(PW)) u_half (
      .val(opnd_a[h*HW +: HW]), .pos(sat_pos), .uns(op_sel == OP_USAT16),
      .out(half_res[h]), .clamped(half_sat[h])
    );
  end

  always_comb begin
    result  = '0;
    sat_any = 1'b0;
    case (op_sel)
      OP_QADD, OP_QSUB, OP_ADDQ, OP_QDBL, OP_UQADD, OP_UQSUB: begin
        result  = as_res;
        sat_any = as_sat;
      end
      OP_SSAT, OP_USAT: begin
        result  = full_res;
        sat_any = full_sat;
      end
      OP_SSAT16, OP_USAT16: begin
        result  = {half_res[1], half_res[0]};
        sat_any = |half_sat;
      end
      default: begin
        result  = '0;
        sat_any = 1'b0;
      end
    endcase
  end

  sat_qflag u_qflag (
    .clk(clk), .rst(rst), .set_en(op_valid & sat_any), .clr(q_clear), .q(q_flag)
  );
endmodule

// File: rtl/sat_arith_chk.sv
module sat_arith_chk #(
  parameter int DW = 32,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [3:0]    op_sel,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b,
  input logic [PW-1:0] sat_pos,
  input logic          q_clear,
  input logic [DW-1:0] result,
  input logic          q_flag
);
  logic [DW:0]   c_sum;
  logic [DW-1:0] c_wrap, c_umax;
  assign c_sum  = {1'b0, opnd_a} + {1'b0, opnd_b};
  assign c_wrap = opnd_a + opnd_b;
  assign c_umax = (DW'(1) << sat_pos) - DW'(1);

  // R13
  a_r13_reset_clears: assert property (@(posedge clk) rst |=> !q_flag);
  // R11
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    (q_flag && !q_clear) |=> q_flag);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !q_flag) |=> !q_flag);
  // R12
  a_r12_clear: assert property (@(posedge clk) disable iff (rst)
    (q_clear && !op_valid) |=> !q_flag);
  // R5
  a_r5_floor: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd4) |-> (result >= opnd_a));
  a_r5_carry_sets_q: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 4'd4 && c_sum[DW]) |=> q_flag);
  // R6
  a_r6_ceiling: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd5) |-> (result <= opnd_a));
  // R8
  a_r8_range: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd7) |-> (result <= c_umax));
  // R1
  a_r1_shape: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 4'd0) |-> (result == c_wrap || result == {1'b0, {(DW-1){1'b1}}}
                          || result == {1'b1, {(DW-1){1'b0}}}));
endmodule

bind sat_arith_unit sat_arith_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_pos(sat_pos), .q_clear(q_clear),
  .result(result), .q_flag(q_flag)
);

// File: tb/sat_arith_unit_tb.sv
module sat_arith_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [4:0]  sat_pos = '0;
  logic        q_clear = 1'b0;
  logic [31:0] result;
  logic        q_flag;

  int checks = 0;
  int failures = 0;
  bit q_m = 1'b0;
  bit done = 1'b0;

  sat_arith_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_pos(sat_pos), .q_clear(q_clear),
    .result(result), .q_flag(q_flag)
  );

  always #5 clk = ~clk;

  function automatic void clampv(input longint v, input int p, input bit u,
                                 output longint r, output bit c);
    longint hi, lo;
    hi = (longint'(1) << p) - 1;
    lo = u ? 0 : -(longint'(1) << p);
    c = 1'b1;
    if (v > hi)      r = hi;
    else if (v < lo) r = lo;
    else begin r = v; c = 1'b0; end
  endfunction

  function automatic void model(input logic [3:0] op, input logic [31:0] a,
                                input logic [31:0] b, input logic [4:0] p,
                                output logic [31:0] r, output bit s);
    longint sa, sb, t, r0, r1;
    bit c0, c1;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    s = 1'b0;
    r = '0;
    case (op)
      4'd0, 4'd1, 4'd2: begin
        t = (op == 4'd1) ? sa - sb : sa + sb;
        if (t > 64'sd2147483647 || t < -64'sd2147483648) s = 1'b1;
        if (op == 4'd2 || !s) r = t[31:0];
        else r = (sa < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      end
      4'd3: begin
        if (sa >= 64'sd1073741824)       begin r = 32'h7FFF_FFFF; s = 1'b1; end
        else if (sa <= -64'sd1073741824) begin r = 32'h8000_0000; s = 1'b1; end
        else r = a << 1;
      end
      4'd4: begin
        t = longint'(a) + longint'(b);
        if (t > 64'h0FFFF_FFFF) begin r = 32'hFFFF_FFFF; s = 1'b1; end
        else r = t[31:0];
      end
      4'd5: begin
        if (b > a) begin r = '0; s = 1'b1; end
        else r = a - b;
      end
      4'd6, 4'd7: begin
        clampv(sa, int'(p), op == 4'd7, r0, c0);
        r = r0[31:0];
        s = c0;
      end
      4'd8, 4'd9: begin
        clampv(longint'($signed(a[15:0])),  int'(p), op == 4'd9, r0, c0);
        clampv(longint'($signed(a[31:16])), int'(p), op == 4'd9, r1, c1);
        r = {r1[15:0], r0[15:0]};
        s = c0 | c1;
      end
      default: begin r = '0; s = 1'b0; end
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
      4'd3: return "R4";  4'd4: return "R5";  4'd5: return "R6";
      4'd6: return "R7";  4'd7: return "R8";  4'd8: return "R9";
      4'd9: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check_q(input string tag);
    checks++;
    if (q_flag !== q_m) begin
      failures++;
      $display("FAIL %s q_flag actual=%0b expected=%0b", tag, q_flag, q_m);
    end
  endtask

  // One operation: drive at the falling edge, check the result, then the flag after the edge.
  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] p, input bit v, input bit c, input string qtag);
    logic [31:0] exp_r;
    bit exp_s;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; sat_pos = p; op_valid = v; q_clear = c;
    model(op, a, b, p, exp_r, exp_s);
    #1;
    checks++;
    if (result !== exp_r) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h s=%0d result actual=%h expected=%h",
               req_of(op), op, a, b, p, result, exp_r);
    end
    @(posedge clk);
    #1;
    if (c) q_m = 1'b0;
    if (v && exp_s) q_m = 1'b1;
    check_q(qtag);
    @(negedge clk);
    op_valid = 1'b0; q_clear = 1'b0;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'h4000_0000 + ($urandom % 5) - 2;
      3: return 32'hC000_0000 + ($urandom % 5) - 2;
      4: return {16'($urandom), 16'h8000 + 16'($urandom % 3) - 16'd1};
      5: return 32'($urandom % 300) - 32'd150;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    q_m = 1'b0;
    check_q("R13 reset");
    @(negedge clk);
    rst = 1'b0;

    // R1 / R3 / R2 corners
    run(4'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 1, 0, "R11 set by R1");
    run(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 0, 1, "R12 clear");
    run(4'd0, 32'h0000_0005, 32'hFFFF_FFF0, 5'd0, 1, 0, "R1 no sat");
    run(4'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd0, 1, 0, "R3 flag");
    run(4'd1, 32'h8000_0000, 32'h1, 5'd0, 0, 1, "R12 clear");
    run(4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 0, 0, "R11 not valid");
    run(4'd1, 32'h0000_0010, 32'h0000_0020, 5'd0, 1, 0, "R2 no sat");
    // R4 thresholds
    run(4'd3, 32'h3FFF_FFFF, 32'h0, 5'd0, 1, 0, "R4 below");
    run(4'd3, 32'hC000_0001, 32'h0, 5'd0, 1, 0, "R4 above low");
    run(4'd3, 32'hC000_0000, 32'h0, 5'd0, 1, 0, "R4 at low threshold");
    run(4'd3, 32'h4000_0000, 32'h0, 5'd0, 1, 1, "R12 set wins over clear");
    // R5 / R6
    run(4'd4, 32'hFFFF_FFFF, 32'h1, 5'd0, 1, 1, "R12 set wins");
    run(4'd4, 32'h1234_0000, 32'h0000_5678, 5'd0, 1, 1, "R12 clear");
    run(4'd5, 32'h5, 32'h6, 5'd0, 1, 0, "R6 borrow");
    run(4'd5, 32'h6, 32'h6, 5'd0, 0, 1, "R12 clear");
    // R7 / R8
    run(4'd6, 32'h0000_0100, 32'h0, 5'd7, 1, 0, "R7 clamp hi");
    run(4'd6, 32'hFFFF_FF80, 32'h0, 5'd7, 0, 1, "R7 edge low");
    run(4'd6, 32'h8000_0000, 32'h0, 5'd31, 1, 0, "R7 pos31 no clamp");
    run(4'd7, 32'hFFFF_FFFF, 32'h0, 5'd8, 1, 0, "R8 negative");
    run(4'd7, 32'h7FFF_FFFF, 32'h0, 5'd31, 0, 1, "R12 clear");
    run(4'd7, 32'h0000_00FF, 32'h0, 5'd8, 1, 0, "R8 edge");
    // R9 / R10
    run(4'd8, 32'h7FFF_8000, 32'h0, 5'd3, 1, 0, "R9 both halves");
    run(4'd8, 32'h0003_FFFC, 32'h0, 5'd3, 0, 1, "R12 clear");
    run(4'd8, 32'h7FFF_8000, 32'h0, 5'd20, 1, 0, "R9 wide pos");
    run(4'd9, 32'h8000_0005, 32'h0, 5'd4, 1, 0, "R10 hi neg");
    run(4'd9, 32'h0009_0020, 32'h0, 5'd4, 0, 1, "R12 clear");
    run(4'd9, 32'h7FFF_1234, 32'h0, 5'd16, 1, 0, "R10 wide pos");
    // R11 unused codes
    run(4'd12, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd0, 1, 0, "R11 unused code");
    run(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd1, 1, 0, "R11 unused code");

    // R13 reset while flag set
    run(4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1, 0, "R11 set");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; q_m = 1'b0; check_q("R13 reset mid-run");
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < 600; i++) begin
      run(4'($urandom % 12), pick(), pick(), 5'($urandom), ($urandom % 3) != 0,
          ($urandom % 6) == 0, "R11 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule